// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block decides when an SDRAM drops into its low-power standby and when it comes back out. It owns the clock-enable pin and the four command pins for the duration of each sleep: it lowers clock-enable together with a no-operation command to go in, holds the command pins deselected while asleep, and raises clock-enable together with a no-operation command to come out. Every output is a flop, so each pin transition is stable for a full clock period before the memory samples it, which meets the clock-enable setup time by construction.

At entry the sequencer samples the per-bank open-row flags and reports which of the two sleep flavours was chosen: with every bank closed it is the precharged flavour, with any row left open it is the active flavour. Because the memory does no refresh while asleep, a dwell timer wakes the device on its own before the refresh interval could be overrun and raises a one-cycle request so that the refresh engine catches up. A wake request that arrives while entry is still under way is remembered and served as soon as entry completes.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: In the awake state, a cycle with `idle_req_i` high, `busy_i` low and `wake_req_i` low causes, one clock later, `cke_o` low together with a NOP command (`cs_n_o`=0, `ras_n_o`=1, `cas_n_o`=1, `we_n_o`=1).
- R2: The NOP on entry lasts exactly one cycle; for the rest of the sleep the command pins show deselect (all four pins high) while `cke_o` stays low.
- R3: `pd_mode_o` becomes 1 if any bit of `bank_open_i` was set in the cycle that started entry and 0 if none was; it then keeps that value, ignoring later changes of `bank_open_i`, until the next entry.
- R4: `cke_o` is never low for more than DWELL_MAX - EXIT_MARGIN + 1 consecutive cycles; with no wake request it is low for exactly that many.
- R5: When the dwell limit ends a sleep, `refresh_req_o` is high for exactly one cycle, the same cycle in which `cke_o` returns high with a NOP.
- R6: A wake request during the sleep makes `cke_o` high with a NOP one clock later, followed by deselect the cycle after; `refresh_req_o` stays low on such an exit.
- R7: A wake request seen in the single cycle after entry starts does not cut entry short: `cke_o` stays low for one more cycle and then returns high with a NOP.
- R8: Entry does not start while `busy_i` or `wake_req_i` is high: `cke_o` stays high and the command pins stay deselected.
- R9: After reset `cke_o` is high, the command pins are deselected, `pd_mode_o` is 0 and `refresh_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req_i | input | 1 | Request to enter power-down |
| wake_req_i | input | 1 | Request to leave power-down |
| busy_i | input | 1 | An access is in progress |
| bank_open_i | input | NUM_BANKS | Per-bank open-row flags |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| pd_mode_o | output | 1 | 1 = active power-down, 0 = precharge power-down |
| refresh_req_o | output | 1 | One-cycle pulse after a forced wake |

## Verification
A wrong state register shows at the pins one clock later, as a clock-enable edge without a NOP, a NOP lasting two cycles, or a sleep that never ends. A dwell counter that is off by one moves the clock-enable rising edge and the refresh pulse by a cycle, which the bench sees by counting low cycles on every forced exit. A mode flag captured at the wrong moment or left transparent shows as soon as the bank flags change during or after a sleep, and a dropped wake held over entry shows as a sleep that runs to the dwell limit.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_PD    = 2'd2,
    ST_EXIT  = 2'd3
  } pd_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  localparam sdram_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdram_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/pd_dwell_timer.sv
module pd_dwell_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = run_i && (cnt_q == LAST);

  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !expire_o); // R4

endmodule

// File: rtl/pd_mode_classifier.sv
module pd_mode_classifier #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 active_mode_o
);

  logic [NUM_BANKS:0] any_open;

  assign any_open[0] = 1'b0;
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_or
    assign any_open[b+1] = any_open[b] | bank_open_i[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_mode_o <= 1'b0;
    end else if (capture_i) begin
      active_mode_o <= any_open[NUM_BANKS];
    end
  end

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> $stable(active_mode_o)); // R3

endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
  import sdram_pd_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int DWELL_MAX   = 6400000,
  parameter int EXIT_MARGIN = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 idle_req_i,
  input  logic                 wake_req_i,
  input  logic                 busy_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 cke_o,
  output logic                 cs_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic                 pd_mode_o,
  output logic                 refresh_req_o
);

  localparam int DWELL_LIMIT = DWELL_MAX - EXIT_MARGIN;
  localparam int LOW_MAX     = DWELL_LIMIT + 1;
  localparam int LW          = $clog2(LOW_MAX + 2);

  pd_state_e  state_q, state_d;
  sdram_cmd_t cmd_q;
  logic       cke_q, refresh_q, wake_pend_q;
  logic       expire, start_entry;

  pd_dwell_timer #(.LIMIT(DWELL_LIMIT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run_i    (state_q == ST_PD),
    .expire_o (expire)
  );

  assign start_entry = (state_q == ST_RUN) && idle_req_i && !busy_i && !wake_req_i;

  pd_mode_classifier #(.NUM_BANKS(NUM_BANKS)) u_mode (
    .clk           (clk),
    .rst           (rst),
    .capture_i     (start_entry),
    .bank_open_i   (bank_open_i),
    .active_mode_o (pd_mode_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (start_entry) state_d = ST_ENTER;
      ST_ENTER: state_d = ST_PD;
      ST_PD:    if (wake_req_i || wake_pend_q || expire) state_d = ST_EXIT;
      ST_EXIT:  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      cke_q       <= 1'b1;
      cmd_q       <= CMD_DESEL;
      refresh_q   <= 1'b0;
      wake_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cke_q       <= !(state_d == ST_ENTER || state_d == ST_PD);
      cmd_q       <= (state_d == ST_ENTER || state_d == ST_EXIT) ? CMD_NOP : CMD_DESEL;
      refresh_q   <= (state_q == ST_PD) && expire;
      wake_pend_q <= (state_q == ST_ENTER) && wake_req_i;
    end
  end

  assign cke_o         = cke_q;
  assign cs_n_o        = cmd_q.cs_n;
  assign ras_n_o       = cmd_q.ras_n;
  assign cas_n_o       = cmd_q.cas_n;
  assign we_n_o        = cmd_q.we_n;
  assign refresh_req_o = refresh_q;

  logic [LW-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (rst || cke_o) low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  AST_ENTRY_GUARDED: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_o) |-> $past(idle_req_i && !busy_i && !wake_req_i)); // R1

  AST_EDGE_WITH_NOP: assert property (@(posedge clk) disable iff (rst)
    ($fell(cke_o) || $rose(cke_o)) |-> (!cs_n_o && ras_n_o && cas_n_o && we_n_o)); // R2

  AST_SLEEP_DESEL: assert property (@(posedge clk) disable iff (rst)
    (!cke_o && $past(!cke_o)) |-> cs_n_o); // R2

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!cke_o && $past(!cke_o)) |-> $stable(pd_mode_o)); // R3

  AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (rst)
    low_run_q <= LW'(LOW_MAX)); // R4

  AST_REFRESH_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
    refresh_req_o |-> ($rose(cke_o) && !$past(refresh_req_o))); // R5

  AST_WAKE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PD && wake_req_i) |=> cke_o); // R6

  AST_BLOCKED_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (cke_o && (busy_i || wake_req_i)) |=> cke_o); // R8

endmodule

// File: tb/sdram_pd_ctrl_bench.sv
module sdram_pd_ctrl_bench;

  localparam int NB  = 4;
  localparam int DM  = 40;
  localparam int EM  = 4;
  localparam int LIM = DM - EM;
  localparam logic [3:0] NOP   = 4'b0111;
  localparam logic [3:0] DESEL = 4'b1111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle = 1'b0, wake = 1'b0, busy = 1'b0;
  logic [NB-1:0] banks = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, mode, refr;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sdram_pd_ctrl #(.NUM_BANKS(NB), .DWELL_MAX(DM), .EXIT_MARGIN(EM)) u_sdram_pd_ctrl (
    .clk(clk), .rst(rst), .idle_req_i(idle), .wake_req_i(wake), .busy_i(busy),
    .bank_open_i(banks), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .pd_mode_o(mode), .refresh_req_o(refr)
  );

  function automatic int cmd();
    return int'({cs_n, ras_n, cas_n, we_n});
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R9 cke", int'(cke), 1);
    chk("R9 cmd", cmd(), int'(DESEL));
    chk("R9 mode", int'(mode), 0);
    chk("R9 refresh", int'(refr), 0);

    // Sweep every bank pattern with and without busy
    for (int p = 0; p < 16; p++) begin
      for (int b = 0; b < 2; b++) begin
        idle = 1'b1; busy = b[0]; banks = p[NB-1:0];
        tick();
        idle = 1'b0; busy = 1'b0;
        if (b == 1) begin
          chk("R8 busy cke", int'(cke), 1);
          chk("R8 busy cmd", cmd(), int'(DESEL));
          tick();
          chk("R8 busy still awake", int'(cke), 1);
        end else begin
          chk("R1 entry cke", int'(cke), 0);
          chk("R1 entry nop", cmd(), int'(NOP));
          banks = ~p[NB-1:0];
          tick();
          chk("R2 sleep cke", int'(cke), 0);
          chk("R2 sleep desel", cmd(), int'(DESEL));
          chk("R3 mode", int'(mode), int'(p != 0));
          wake = 1'b1;
          tick();
          wake = 1'b0;
          chk("R6 wake cke", int'(cke), 1);
          chk("R6 wake nop", cmd(), int'(NOP));
          chk("R6 no refresh", int'(refr), 0);
          tick();
          chk("R6 desel after", cmd(), int'(DESEL));
          chk("R3 mode held", int'(mode), int'(p != 0));
        end
      end
    end

    // Wake request blocks entry
    idle = 1'b1; wake = 1'b1;
    tick();
    idle = 1'b0; wake = 1'b0;
    chk("R8 wake blocks cke", int'(cke), 1);
    chk("R8 wake blocks cmd", cmd(), int'(DESEL));
    tick();

    // Forced exit at the dwell limit
    for (int q = 0; q < 2; q++) begin
      int cnt;
      int bad;
      banks = (q == 0) ? 4'b0000 : 4'b0101;
      idle = 1'b1;
      tick();
      idle = 1'b0;
      cnt = 0;
      bad = 0;
      while (cke == 1'b0 && cnt < 1000) begin
        cnt++;
        if (refr) bad++;
        banks = ~banks;
        tick();
      end
      chk("R4 low cycles", cnt, LIM + 1);
      chk("R5 no early refresh", bad, 0);
      chk("R5 refresh pulse", int'(refr), 1);
      chk("R5 exit nop", cmd(), int'(NOP));
      chk("R3 mode through dwell", int'(mode), q);
      tick();
      chk("R5 pulse ends", int'(refr), 0);
      chk("R5 desel", cmd(), int'(DESEL));
    end

    // Wake in the entry cycle
    banks = '0;
    idle = 1'b1;
    tick();
    idle = 1'b0; wake = 1'b1;
    tick();
    wake = 1'b0;
    chk("R7 still low", int'(cke), 0);
    tick();
    chk("R7 exit cke", int'(cke), 1);
    chk("R7 exit nop", cmd(), int'(NOP));
    chk("R7 no refresh", int'(refr), 0);
    tick();

    // Wake at every depth inside the dwell window
    for (int d = 1; d < LIM; d++) begin
      idle = 1'b1;
      tick();
      idle = 1'b0;
      repeat (d) tick();
      chk("R6 low before wake", int'(cke), 0);
      wake = 1'b1;
      tick();
      wake = 1'b0;
      chk("R6 depth cke", int'(cke), 1);
      chk("R6 depth refresh", int'(refr), 0);
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule